// File: doc/BRIEF.md
# Bus Idle Handshake Sequencer

This block wins a quiet PCI bus before a hot-plug slot is attached. Local control logic raises a one-cycle connect request. The block then lowers an active-low idle request toward the host bridge. It waits for the active-low idle grant. After the grant, it waits until both FRAME and IRDY read inactive. Only then does it return a one-cycle connect-permitted strobe. One clock later it releases the idle request. The grant alone never permits a connection.

A second, downstream controller can hang off the block. That controller's idle request enters as an active-low secondary request. The block forwards it upstream on its own idle request. Once the host grants, the block answers with an active-low secondary grant, and the downstream controller checks the bus itself. Local work takes priority over the downstream controller. The upstream request stays low until every pending user has been served.

Everything runs on the PCI clock. The grant, FRAME, IRDY and secondary request inputs each pass through a `SYNC_STAGES`-deep synchronizer (default 2) before any decision uses them. The connect request comes from local synchronous logic and is not synchronized.

Top module: `bus_idle_seq`

## Requirements
- R1: While `rstN` is low, and afterwards until a request arrives, `idleReqN` and `secGntN` are high and `connGo` is low.
- R2: A one-cycle high pulse on `connReq` is captured at edge k, and `idleReqN` goes low after edge k+1.
- R3: The synchronizer is `SYNC_STAGES` flops deep. While a local request waits, suppose that at edge m `idleGntN` is low and `frameN` and `irdyN` are both high, and they are held. Then `connGo` is high for exactly the cycle after edge m+`SYNC_STAGES`.
- R4: While `frameN` or `irdyN` is low, `connGo` stays low, even when the grant is held low.
- R5: `connGo` is one cycle wide. With no secondary request pending, `idleReqN` returns high at the edge after `connGo`.
- R6: A low level on `secReqN` first sampled at edge k drives `idleReqN` low after edge k+`SYNC_STAGES`.
- R7: While a secondary request is being served, a grant first sampled low at edge m drives `secGntN` low after edge m+`SYNC_STAGES`. This happens whatever the state of FRAME and IRDY.
- R8: `secGntN` goes high in the same cycle that `secReqN` goes high, without waiting for a clock edge.
- R9: With no local request pending, a rise of `secReqN` first sampled at edge k returns `idleReqN` high after edge k+`SYNC_STAGES`.
- R10: When local and secondary requests are both pending, `connGo` comes first while `secGntN` is high. After that the secondary request is granted, and `idleReqN` stays low throughout.
- R11: `secReqN` held high (no request) has no effect: activity on the grant leaves `idleReqN` and `secGntN` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rstN | input | 1 | PCI reset, active low, asynchronous |
| connReq | input | 1 | One-cycle slot-connect request from local control |
| connGo | output | 1 | One-cycle strobe: slot may connect now |
| idleReqN | output | 1 | Idle request to host bridge, active low |
| idleGntN | input | 1 | Idle grant from host bridge, active low |
| frameN | input | 1 | Bus FRAME, active low |
| irdyN | input | 1 | Bus IRDY, active low |
| secReqN | input | 1 | Idle request from cascaded controller, active low |
| secGntN | output | 1 | Grant to cascaded controller, active low |

## Verification
The assertions assume the following about the inputs:
- The cascaded controller holds `secReqN` low until it has been granted and has finished its work.
- The host does not pull the grant back while the secondary grant is out.
- `connReq` is a single-cycle pulse.

The stimulus follows all three rules. Every input changes only on the falling clock edge. The secondary request is withdrawn only after the secondary grant has been observed. The grant is released only after the block has dropped its idle request.

// File: rtl/bis_pkg.sv
package bis_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LREQ  = 3'd1,
    ST_LDONE = 3'd2,
    ST_SREQ  = 3'd3,
    ST_SGNT  = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic reqUp;
    logic connGo;
    logic grantSec;
    logic clrLocal;
  } ctlStrobes_t;

  // qualified status from datapath to control
  typedef struct packed {
    logic localPend;
    logic gntSeen;
    logic busIdle;
    logic secPend;
  } dpStatus_t;

  localparam int unsigned SYNC_W = 4;
  localparam int unsigned IDX_GNT   = 0;
  localparam int unsigned IDX_FRAME = 1;
  localparam int unsigned IDX_IRDY  = 2;
  localparam int unsigned IDX_SREQ  = 3;

endpackage

// File: rtl/bis_sync.sv
module bis_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 4,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= RESET_VAL;
          else       chain[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= RESET_VAL;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/bis_datapath.sv
module bis_datapath
  import bis_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        connReq,
  input  logic        idleGntN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic        secReqN,
  input  ctlStrobes_t ctl,
  output dpStatus_t   stat,
  output logic        connGo,
  output logic        idleReqN,
  output logic        secGntN
);

  logic [SYNC_W-1:0] rawIn;
  logic [SYNC_W-1:0] syncIn;
  logic              localPendQ;

  always_comb begin
    rawIn            = '1;
    rawIn[IDX_GNT]   = idleGntN;
    rawIn[IDX_FRAME] = frameN;
    rawIn[IDX_IRDY]  = irdyN;
    rawIn[IDX_SREQ]  = secReqN;
  end

  bis_sync #(
    .STAGES    (SYNC_STAGES),
    .WIDTH     (SYNC_W),
    .RESET_VAL ({SYNC_W{1'b1}})
  ) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (rawIn),
    .dout (syncIn)
  );

  // a new pulse wins over the clear of the request just served
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             localPendQ <= 1'b0;
    else if (connReq)      localPendQ <= 1'b1;
    else if (ctl.clrLocal) localPendQ <= 1'b0;
  end

  always_comb begin
    stat.localPend = localPendQ;
    stat.gntSeen   = ~syncIn[IDX_GNT];
    stat.busIdle   = syncIn[IDX_FRAME] & syncIn[IDX_IRDY];
    stat.secPend   = ~syncIn[IDX_SREQ];
  end

  assign connGo   = ctl.connGo;
  assign idleReqN = ~ctl.reqUp;
  // withdrawal releases the grant at once, without waiting for the synchronizer
  assign secGntN  = ~(ctl.grantSec & ~secReqN);

endmodule

// File: rtl/bis_control.sv
module bis_control
  import bis_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   stat,
  output ctlStrobes_t ctl
);

  seqState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (stat.localPend)    stateD = ST_LREQ;
        else if (stat.secPend) stateD = ST_SREQ;
      end
      ST_LREQ: begin
        if (stat.gntSeen && stat.busIdle) stateD = ST_LDONE;
      end
      ST_LDONE: begin
        stateD = stat.secPend ? ST_SREQ : ST_IDLE;
      end
      ST_SREQ: begin
        if (stat.localPend)     stateD = ST_LREQ;
        else if (!stat.secPend) stateD = ST_IDLE;
        else if (stat.gntSeen)  stateD = ST_SGNT;
      end
      ST_SGNT: begin
        if (!stat.secPend) stateD = stat.localPend ? ST_LREQ : ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.reqUp    = (stateQ != ST_IDLE);
    ctl.connGo   = (stateQ == ST_LDONE);
    ctl.grantSec = (stateQ == ST_SGNT);
    ctl.clrLocal = (stateQ == ST_LDONE);
  end

endmodule

// File: rtl/bus_idle_seq.sv
module bus_idle_seq
  import bis_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic connReq,
  output logic connGo,
  output logic idleReqN,
  input  logic idleGntN,
  input  logic frameN,
  input  logic irdyN,
  input  logic secReqN,
  output logic secGntN
);

  ctlStrobes_t ctl;
  dpStatus_t   stat;

  bis_datapath #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .connReq  (connReq),
    .idleGntN (idleGntN),
    .frameN   (frameN),
    .irdyN    (irdyN),
    .secReqN  (secReqN),
    .ctl      (ctl),
    .stat     (stat),
    .connGo   (connGo),
    .idleReqN (idleReqN),
    .secGntN  (secGntN)
  );

  bis_control u_ctl (
    .clk  (clk),
    .rstN (rstN),
    .stat (stat),
    .ctl  (ctl)
  );

endmodule

// File: rtl/bis_checker.sv
module bis_checker (
  input logic clk,
  input logic rstN,
  input logic connGo,
  input logic idleReqN,
  input logic secReqN,
  input logic secGntN
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (idleReqN && secGntN && !connGo)); // R1

  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    connGo |=> !connGo); // R5

  AST_GO_UNDER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    connGo |-> (!idleReqN && !$past(idleReqN))); // R3

  AST_SGNT_NEEDS_SREQ: assert property (@(posedge clk) disable iff (!rstN)
    !secGntN |-> (!secReqN && !idleReqN)); // R8

  AST_GRANTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !secGntN |-> !connGo); // R10

endmodule

bind bus_idle_seq bis_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .connGo   (connGo),
  .idleReqN (idleReqN),
  .secReqN  (secReqN),
  .secGntN  (secGntN)
);

// File: tb/bus_idle_seq_bench.sv
module bus_idle_seq_bench;

  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic connReq = 1'b0;
  logic idleGntN = 1'b1;
  logic frameN = 1'b1;
  logic irdyN = 1'b1;
  logic secReqN = 1'b1;
  logic connGo, idleReqN, secGntN;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bus_idle_seq #(.SYNC_STAGES(SYNC)) u_bus_idle_seq (
    .clk      (clk),
    .rstN     (rstN),
    .connReq  (connReq),
    .connGo   (connGo),
    .idleReqN (idleReqN),
    .idleGntN (idleGntN),
    .frameN   (frameN),
    .irdyN    (irdyN),
    .secReqN  (secReqN),
    .secGntN  (secGntN)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic nedge(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulseReq();
    connReq = 1'b1;
    @(negedge clk);
    connReq = 1'b0;
  endtask

  initial begin
    // R1: reset state
    nedge(3);
    chk("R1 reset idleReqN", idleReqN, 1'b1);
    chk("R1 reset secGntN", secGntN, 1'b1);
    chk("R1 reset connGo", connGo, 1'b0);
    rstN = 1'b1;
    for (int k = 0; k < 4; k++) begin
      nedge(1);
      chk("R1 quiet idleReqN", idleReqN, 1'b1);
      chk("R1 quiet connGo", connGo, 1'b0);
    end

    // R2..R5 sweep over FRAME, IRDY and grant delay
    for (int f = 0; f < 2; f++) begin
      for (int i = 0; i < 2; i++) begin
        for (int d = 0; d < 3; d++) begin
          pulseReq();
          chk("R2 idleReqN before", idleReqN, 1'b1);
          nedge(1);
          chk("R2 idleReqN low", idleReqN, 1'b0);
          nedge(d);
          idleGntN = 1'b0;
          frameN = f[0];
          irdyN = i[0];
          for (int k = 1; k <= SYNC; k++) begin
            nedge(1);
            chk("R3 no early connGo", connGo, 1'b0);
          end
          nedge(1);
          chk(((f & i) != 0) ? "R3 connGo" : "R4 blocked", connGo, logic'((f & i) != 0));
          if ((f & i) == 0) begin
            for (int k = 0; k < 3; k++) begin
              nedge(1);
              chk("R4 still blocked", connGo, 1'b0);
            end
            frameN = 1'b1;
            irdyN = 1'b1;
            nedge(SYNC + 1);
            chk("R3 connGo after idle", connGo, 1'b1);
          end
          chk("R5 idleReqN held at go", idleReqN, 1'b0);
          nedge(1);
          chk("R5 connGo one cycle", connGo, 1'b0);
          chk("R5 idleReqN released", idleReqN, 1'b1);
          idleGntN = 1'b1;
          nedge(SYNC + 2);
        end
      end
    end

    // R6..R9 secondary path, with the bus busy to show it is not required
    frameN = 1'b0;
    secReqN = 1'b0;
    for (int k = 1; k <= SYNC; k++) begin
      nedge(1);
      chk("R6 idleReqN not yet", idleReqN, 1'b1);
    end
    nedge(1);
    chk("R6 idleReqN low", idleReqN, 1'b0);
    idleGntN = 1'b0;
    for (int k = 1; k <= SYNC; k++) begin
      nedge(1);
      chk("R7 secGntN not yet", secGntN, 1'b1);
    end
    nedge(1);
    chk("R7 secGntN low", secGntN, 1'b0);
    chk("R7 no local go", connGo, 1'b0);
    nedge(2);
    secReqN = 1'b1;
    #0.5;
    chk("R8 secGntN immediate", secGntN, 1'b1);
    for (int k = 1; k <= SYNC; k++) begin
      nedge(1);
      chk("R9 idleReqN held", idleReqN, 1'b0);
    end
    nedge(1);
    chk("R9 idleReqN released", idleReqN, 1'b1);
    idleGntN = 1'b1;
    frameN = 1'b1;
    nedge(SYNC + 2);

    // R10: both pending, local first
    secReqN = 1'b0;
    pulseReq();
    nedge(1);
    chk("R10 idleReqN low", idleReqN, 1'b0);
    idleGntN = 1'b0;
    nedge(SYNC + 1);
    chk("R10 local go first", connGo, 1'b1);
    chk("R10 no sec grant at go", secGntN, 1'b1);
    nedge(1);
    chk("R10 idleReqN kept", idleReqN, 1'b0);
    chk("R10 sec grant waits", secGntN, 1'b1);
    nedge(1);
    chk("R10 sec grant", secGntN, 1'b0);
    chk("R10 idleReqN kept 2", idleReqN, 1'b0);
    secReqN = 1'b1;
    nedge(SYNC + 1);
    chk("R10 released", idleReqN, 1'b1);
    idleGntN = 1'b1;
    nedge(SYNC + 2);

    // R11: no secondary request, grant toggles
    for (int k = 0; k < 10; k++) begin
      idleGntN = k[0];
      nedge(1);
      chk("R11 idleReqN idle", idleReqN, 1'b1);
      chk("R11 secGntN idle", secGntN, 1'b1);
    end
    idleGntN = 1'b1;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule